// File: doc/BRIEF.md
# Interrupt Enable and Periodic Timer Unit

This block gathers the interrupt sources of a small microcontroller into one request line. An 8-bit enable register, reachable at a single bus address, selects which of five sources may raise the request: a wake-up timer, a GPIO event, a millisecond timer tick, a 128 µs timer tick and a USB bus reset / PS/2 activity event. Each enabled source sets its own sticky pending flag. The CPU request output is high while any flag is set.

A free-running divider runs on the 6 MHz block clock and produces both timer ticks. The 128 µs tick comes every 768 cycles. The millisecond tick comes on every eighth 128 µs tick, which is every 6144 cycles. The wake-up timer is a separate counter. It is held at zero while its enable bit is 0 and counts only while that bit is 1, so it fires a fixed number of cycles after it is enabled. Software clears a pending flag by giving an acknowledge with the source's index.

Top module: `irq_timer_unit`

## Requirements
- R1: After reset the enable register reads 0x00, `pending` is 0x00 and `irq` is 0.
- R2: A write with `addr` equal to 0x20 stores bits 7, 6, 2, 1 and 0 of `wdata`. Bits 5:3 are not stored and always read 0. `rdata` shows the register while `addr` is 0x20 and is 0 at any other address. A write to any other address leaves the register unchanged.
- R3: While enable bit 1 is 1, pending bit 1 is set once every 768 clock cycles by the free-running 128 µs tick.
- R4: While enable bit 2 is 1, pending bit 2 is set once every 6144 clock cycles by the millisecond tick.
- R5: While enable bit 7 is 1, the wake-up counter sets pending bit 7 every WAKE_CYCLES cycles. The first set comes WAKE_CYCLES cycles after the write that enabled it. While bit 7 is 0 the counter is held at zero and never sets the flag.
- R6: A high `gpio_evt` sets pending bit 6 at the next clock edge, and a high `bus_evt` sets pending bit 0, provided the enable bit of the same position is 1.
- R7: A source whose enable bit is 0 never sets its pending bit.
- R8: A pending bit stays set until a cycle with `ack_valid` high and `ack_src` equal to that bit's position clears it. An acknowledge that carries another index leaves the bit unchanged.
- R9: If a source event and the acknowledge for the same bit arrive in the same cycle, the pending bit is set after that edge.
- R10: `irq` is 1 exactly when at least one bit of `pending` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 6 MHz block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| gpio_evt | input | 1 | GPIO interrupt event, high for one cycle per event |
| bus_evt | input | 1 | USB bus reset / PS/2 activity event |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_src | input | 3 | Bit index of the source being acknowledged |
| pending | output | 8 | Sticky pending flags, one per enable bit |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume that `gpio_evt` and `bus_evt` are already synchronous to `clk`. They also assume that an acknowledge names one source per cycle. The bench drives every input on the falling edge, so each event, write and acknowledge is a clean one-cycle pulse seen by exactly one rising edge. The bench measures tick periods as the distance between two consecutive pending rises, with an acknowledge in between. Because of this it never depends on the divider's phase at the moment a source is enabled, except for the wake-up timer, whose phase is defined by the enabling write.

// File: rtl/irq_timer_unit.sv
module irq_timer_unit #(
  parameter logic [7:0] REG_ADDR    = 8'h20,
  parameter int         US_DIV      = 768,
  parameter int         MS_PER_US   = 8,
  parameter int         WAKE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       gpio_evt,
  input  logic       bus_evt,
  input  logic       ack_valid,
  input  logic [2:0] ack_src,
  output logic [7:0] pending,
  output logic       irq
);
  localparam logic [7:0] WMASK = 8'hC7;
  localparam int UW = $clog2(US_DIV + 1);
  localparam int MW = $clog2(MS_PER_US + 1);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  logic [7:0]    en;
  logic [7:0]    evt;
  logic [7:0]    pend_d;
  logic [UW-1:0] us_cnt;
  logic [MW-1:0] ms_cnt;
  logic [WW-1:0] wk_cnt;
  logic          us_tick, ms_tick, wk_tick, sel;

  assign sel     = (addr == REG_ADDR);
  assign rdata   = sel ? en : 8'h00;
  assign us_tick = (us_cnt == UW'(US_DIV - 1));
  assign ms_tick = us_tick && (ms_cnt == MW'(MS_PER_US - 1));
  assign wk_tick = en[7] && (wk_cnt == WW'(WAKE_CYCLES - 1));
  assign evt     = {wk_tick, gpio_evt, 3'b000, ms_tick, us_tick, bus_evt};
  assign irq     = |pending;

  always_comb
    for (int i = 0; i < 8; i++)
      pend_d[i] = (evt[i] & en[i]) | (pending[i] & !(ack_valid && ack_src == 3'(i)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en      <= '0;
      pending <= '0;
      us_cnt  <= '0;
      ms_cnt  <= '0;
      wk_cnt  <= '0;
    end else begin
      if (wr_en && sel) en <= wdata & WMASK;
      pending <= pend_d;
      us_cnt  <= us_tick ? '0 : us_cnt + 1'b1;
      if (us_tick) ms_cnt <= ms_tick ? '0 : ms_cnt + 1'b1;
      if (!en[7])       wk_cnt <= '0;
      else if (wk_tick) wk_cnt <= '0;
      else              wk_cnt <= wk_cnt + 1'b1;
    end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[5:3] == 3'b000);
  a_r7_gpio_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending[6] && !en[6]) |=> !pending[6]);
  a_r8_sticky_us: assert property (@(posedge clk) disable iff (!rst_n)
    (pending[1] && !(ack_valid && ack_src == 3'd1)) |=> pending[1]);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_evt && en[0]) |=> pending[0]);
  a_r5_wake_held: assert property (@(posedge clk) disable iff (!rst_n)
    !en[7] |=> (wk_cnt == '0));
  a_r10_irq_any: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (pending != 8'h00));
endmodule

// File: tb/test_irq_timer_unit.sv
module test_irq_timer_unit;
  localparam int WAKE = 64;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic wr_en = 0, gpio_evt = 0, bus_evt = 0, ack_valid = 0;
  logic [2:0] ack_src = 0;
  logic [7:0] rdata, pending;
  logic irq;
  int checks = 0, failures = 0, cyc = 0;

  irq_timer_unit #(.WAKE_CYCLES(WAKE)) i_irq_timer_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .gpio_evt(gpio_evt), .bus_evt(bus_evt),
    .ack_valid(ack_valid), .ack_src(ack_src), .pending(pending), .irq(irq));

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual cyc=%0d expected <150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = 8'h20;
  endtask

  task automatic ack(input int b);
    @(negedge clk); ack_valid = 1; ack_src = 3'(b);
    @(negedge clk); ack_valid = 0;
  endtask

  task automatic wait_pend(input int b, output int stamp);
    stamp = -1;
    for (int k = 0; k < 10000; k++) begin
      @(negedge clk);
      if (pending[b]) begin stamp = cyc; break; end
    end
  endtask

  task automatic t_reset();
    addr = 8'h20;
    #1;
    chk(rdata == 8'h00, "R1 reg", rdata, 0);
    chk(pending == 8'h00, "R1 pending", pending, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_regs();
    wr(8'h20, 8'hFF);
    chk(rdata == 8'hC7, "R2 write mask", rdata, 8'hC7);
    wr(8'h20, 8'h00);
    wr(8'h21, 8'h41);
    chk(rdata == 8'h00, "R2 other addr write", rdata, 0);
    wr(8'h20, 8'h40);
    addr = 8'h1F; #1;
    chk(rdata == 8'h00, "R2 other addr read", rdata, 0);
    addr = 8'h20; #1;
    chk(rdata == 8'h40, "R2 readback", rdata, 8'h40);
    wr(8'h20, 8'h00);
  endtask

  task automatic t_period(input int b, input logic [7:0] enm, input int per, input string req);
    int s0, s1;
    wr(8'h20, enm);
    wait_pend(b, s0);
    ack(b);
    chk(pending[b] == 1'b0, req, pending[b], 0);
    wait_pend(b, s1);
    chk(s0 >= 0 && s1 - s0 == per, req, s1 - s0, per);
    ack(b);
    wr(8'h20, 8'h00);
  endtask

  task automatic t_wake();
    int s0, s1;
    @(negedge clk); addr = 8'h20; wdata = 8'h80; wr_en = 1;
    @(posedge clk); s0 = cyc + 1;
    @(negedge clk); wr_en = 0;
    wait_pend(7, s1);
    chk(s1 - s0 == WAKE, "R5 first wake", s1 - s0, WAKE);
    ack(7);
    wr(8'h20, 8'h00);
    repeat (3 * WAKE) @(negedge clk);
    chk(pending[7] == 1'b0, "R5 disabled held", pending[7], 0);
    @(negedge clk); wdata = 8'h80; wr_en = 1;
    @(posedge clk); s0 = cyc + 1;
    @(negedge clk); wr_en = 0;
    wait_pend(7, s1);
    chk(s1 - s0 == WAKE, "R5 restart from zero", s1 - s0, WAKE);
    ack(7);
    wr(8'h20, 8'h00);
  endtask

  task automatic t_ext();
    @(negedge clk); gpio_evt = 1; bus_evt = 1;
    @(negedge clk); gpio_evt = 0; bus_evt = 0;
    chk(pending == 8'h00, "R7 disabled sources", pending, 0);
    chk(irq == 1'b0, "R10 irq idle", irq, 0);
    wr(8'h20, 8'h41);
    @(negedge clk); gpio_evt = 1;
    @(negedge clk); gpio_evt = 0;
    chk(pending == 8'h40, "R6 gpio set", pending, 8'h40);
    chk(irq == 1'b1, "R10 irq on", irq, 1);
    @(negedge clk); bus_evt = 1;
    @(negedge clk); bus_evt = 0;
    chk(pending == 8'h41, "R6 bus set", pending, 8'h41);
  endtask

  task automatic t_ack();
    ack(2);
    chk(pending == 8'h41, "R8 other index", pending, 8'h41);
    ack(6);
    chk(pending == 8'h01, "R8 gpio cleared", pending, 8'h01);
    @(negedge clk); bus_evt = 1; ack_valid = 1; ack_src = 3'd0;
    @(negedge clk); bus_evt = 0; ack_valid = 0;
    chk(pending == 8'h01, "R9 set wins", pending, 8'h01);
    ack(0);
    chk(pending == 8'h00, "R8 bus cleared", pending, 0);
    chk(irq == 1'b0, "R10 irq off", irq, 0);
    wr(8'h20, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_ext();
    t_ack();
    t_period(1, 8'h02, 768, "R3 128us period");
    t_period(2, 8'h04, 6144, "R4 ms period");
    t_wake();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule